// File: doc/BRIEF.md
# Interval Timer with Watchdog Clock Divider

This block is a binary prescaler of fourteen stages followed by two tap selectors. One selector picks the stage that drives an interval-timer tick. The tick leaves the block as a one-cycle timer pulse and, when the interrupt mask allows it, as an interrupt request. The other selector picks a coarse stage. After a divide-by-8 stage, that choice becomes the watchdog clock. All stages form one synchronous counter that runs on the system clock and advances on a clock enable. That enable is either the source enable itself or the source enable divided by 16, which gives the slow sub-clock rate.

A 4-bit control register is loaded through a single write strobe. The three low bits choose the interval tap. The top bit asks for a restart of the prescaler when the write happens. The restart only takes place while the watchdog lock input is high. With the lock low, the write still loads the register but the count keeps running. A system asserts the write strobe to reprogram the rate and, if allowed, to realign the timer phase to the write.

Top module: `itvwd_timer`

## Requirements
- R1: While reset is held, `ctl_value` reads 4'b1111 and `tick_o`, `irq_o` and `wd_clk_o` are 0, and the prescaler count is zero.
- R2: A write (`ctl_wr`=1) loads `ctl_wdata` into the control register at that clock edge. Bit 3 is the restart-mode bit and bits 2:0 are the interval select. Without a write, the register holds its value.
- R3: A write whose bit 3 is 1 while `wd_lock`=1 clears every prescaler stage and the divide-by-16 prestage at the write edge. Counting resumes from zero.
- R4: When `wd_lock`=0, a write never restarts the prescaler, whatever bit 3 holds. When bit 3 is 0, no write restarts it. The register is still loaded.
- R5: Stage Qk is count bit k-1. Interval select codes 0,1,2,3,4,5,6,7 choose Q1,Q2,Q3,Q4,Q5,Q6,Q8,Q11 in that order, so code c gives one tick per 2^k prescaler advances for its stage k.
- R6: `tick_o` is high for exactly one clock cycle each time the selected interval tap goes from 0 to 1.
- R7: `irq_o` follows `tick_o` while `irq_mask`=1 and stays 0 while `irq_mask`=0.
- R8: The prescaler advances only on cycles with `src_en`=1 and holds on all other cycles.
- R9: With `sub_sel`=1, the prescaler advances once for every 16 enabled source cycles, and the divide-by-16 prestage wraps on the 16th.
- R10: `wd_sel` values 0, 1 and 2-or-3 choose Q8, Q11 and Q14. `wd_clk_o` is bit 2 of a 3-bit counter that steps on each rise of that tap, so it toggles every four rises.
- R11: Reset release is synchronized. The block starts working on the third clock edge after `rst_n` rises, and writes before that edge are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_en | input | 1 | Source clock enable for the prescaler |
| sub_sel | input | 1 | 1: divide the source enable by 16 first |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 4 | Write data: bit 3 restart mode, bits 2:0 interval select |
| wd_lock | input | 1 | 1 permits a restart on write |
| wd_sel | input | 2 | Watchdog tap select |
| irq_mask | input | 1 | 1 passes the tick onto the interrupt line |
| ctl_value | output | 4 | Current control register contents |
| tick_o | output | 1 | One-cycle interval timer pulse |
| irq_o | output | 1 | Masked interrupt request |
| wd_clk_o | output | 1 | Divided watchdog clock |

## Verification
The interval path runs through all eight select codes with a steady enable. This separates a wrong tap mapping from a wrong tick width, because each code has a distinct tick period. A ragged random enable, and then the divided sub-clock mode, show whether the prescaler advances on the right cycles rather than on every clock. Restart writes are tried with the lock high and low and with bit 3 both set and clear, and they land mid-count. A missing clear or a clear that should have been blocked then shifts every later tick. The watchdog path runs long enough on each of its three taps that a wrong tap or a wrong divide ratio moves the toggle of `wd_clk_o`.

// File: rtl/itvwd_pkg.sv
package itvwd_pkg;

  localparam int unsigned ITV_TAPS = 8;
  localparam int unsigned WD_TAPS  = 3;

  typedef struct packed {
    logic       restart_mode;
    logic [2:0] div_sel;
  } ctl_t;

  localparam ctl_t CTL_RESET = '{restart_mode: 1'b1, div_sel: 3'b111};

  // interval select code -> prescaler stage number (1-based)
  function automatic int unsigned itv_stage(input int unsigned code);
    int unsigned s;
    if (code <= 5)      s = code + 1;
    else if (code == 6) s = 8;
    else                s = 11;
    return s;
  endfunction

  // watchdog select code -> prescaler stage number (1-based)
  function automatic int unsigned wd_stage(input int unsigned code);
    int unsigned s;
    if (code == 0)      s = 8;
    else if (code == 1) s = 11;
    else                s = 14;
    return s;
  endfunction

endpackage

// File: rtl/itvwd_prestage.sv
module itvwd_prestage #(
  parameter int unsigned PRE_DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic src_en,
  input  logic sub_sel,
  output logic step
);
  localparam int unsigned W = $clog2(PRE_DIV);
  localparam logic [W-1:0] LAST = W'(PRE_DIV - 1);

  logic [W-1:0] cnt_q, cnt_d;
  logic         wrap;

  assign wrap = (cnt_q == LAST);
  assign step = src_en & (sub_sel ? wrap : 1'b1);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)
      cnt_d = '0;
    else if (src_en && sub_sel)
      cnt_d = wrap ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/itvwd_ripple.sv
module itvwd_ripple #(
  parameter int unsigned STAGES = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              step,
  output logic [STAGES-1:0] q
);
  logic [STAGES-1:0] q_q, q_d;

  always_comb begin
    q_d = q_q;
    if (clr)       q_d = '0;
    else if (step) q_d = q_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= '0;
    else        q_q <= q_d;
  end

  assign q = q_q;
endmodule

// File: rtl/itvwd_tapmux.sv
module itvwd_tapmux #(
  parameter int unsigned N     = 8,
  parameter int unsigned SEL_W = 3
) (
  input  logic [N-1:0]     taps,
  input  logic [SEL_W-1:0] sel,
  output logic             tap
);
  // codes at or above N fall back to the last tap
  always_comb begin
    tap = taps[N-1];
    for (int i = 0; i < N; i++) begin
      if (int'(sel) == i) tap = taps[i];
    end
  end
endmodule

// File: rtl/itvwd_rise.sv
module itvwd_rise (
  input  logic clk,
  input  logic rst_n,
  input  logic sig,
  output logic rise
);
  logic prev_q, prev_d;

  assign prev_d = sig;
  assign rise   = sig & ~prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= prev_d;
  end
endmodule

// File: rtl/itvwd_div.sv
module itvwd_div #(
  parameter int unsigned W = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  output logic msb
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (adv) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign msb = cnt_q[W-1];
endmodule

// File: rtl/itvwd_timer.sv
module itvwd_timer
  import itvwd_pkg::*;
#(
  parameter int unsigned STAGES   = 14,
  parameter int unsigned PRE_DIV  = 16,
  parameter int unsigned WD_DIV_W = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       src_en,
  input  logic       sub_sel,
  input  logic       ctl_wr,
  input  logic [3:0] ctl_wdata,
  input  logic       wd_lock,
  input  logic [1:0] wd_sel,
  input  logic       irq_mask,
  output logic [3:0] ctl_value,
  output logic       tick_o,
  output logic       irq_o,
  output logic       wd_clk_o
);
  localparam int unsigned ITV_SEL_W = $clog2(ITV_TAPS);
  localparam int unsigned WD_SEL_W  = $clog2(WD_TAPS);

  // reset: asserted at once, released after two edges
  logic rst_s1_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s1_q   <= 1'b1;
      rst_sync_n <= rst_s1_q;
    end
  end

  // control register
  ctl_t ctl_q, ctl_d, wr_view;
  logic restart;

  assign wr_view = ctl_t'(ctl_wdata);
  assign restart = ctl_wr & wr_view.restart_mode & wd_lock;

  always_comb begin
    ctl_d = ctl_q;
    if (ctl_wr) ctl_d = wr_view;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) ctl_q <= CTL_RESET;
    else             ctl_q <= ctl_d;
  end

  assign ctl_value = ctl_q;

  // prescaler
  logic              step;
  logic [STAGES-1:0] stage_q;

  itvwd_prestage #(.PRE_DIV(PRE_DIV)) u_pre (
    .clk(clk), .rst_n(rst_sync_n), .clr(restart),
    .src_en(src_en), .sub_sel(sub_sel), .step(step)
  );

  itvwd_ripple #(.STAGES(STAGES)) u_cnt (
    .clk(clk), .rst_n(rst_sync_n), .clr(restart),
    .step(step), .q(stage_q)
  );

  // tap vectors
  logic [ITV_TAPS-1:0] itv_taps;
  logic [WD_TAPS-1:0]  wd_taps;

  for (genvar g = 0; g < ITV_TAPS; g++) begin : g_itv
    assign itv_taps[g] = stage_q[itv_stage(g) - 1];
  end
  for (genvar g = 0; g < WD_TAPS; g++) begin : g_wd
    assign wd_taps[g] = stage_q[wd_stage(g) - 1];
  end

  // interval path
  logic itv_tap;
  itvwd_tapmux #(.N(ITV_TAPS), .SEL_W(ITV_SEL_W)) u_itv_mux (
    .taps(itv_taps), .sel(ctl_q.div_sel), .tap(itv_tap)
  );
  itvwd_rise u_itv_edge (
    .clk(clk), .rst_n(rst_sync_n), .sig(itv_tap), .rise(tick_o)
  );
  assign irq_o = tick_o & irq_mask;

  // watchdog path
  logic wd_tap, wd_rise;
  itvwd_tapmux #(.N(WD_TAPS), .SEL_W(WD_SEL_W)) u_wd_mux (
    .taps(wd_taps), .sel(wd_sel), .tap(wd_tap)
  );
  itvwd_rise u_wd_edge (
    .clk(clk), .rst_n(rst_sync_n), .sig(wd_tap), .rise(wd_rise)
  );
  itvwd_div #(.W(WD_DIV_W)) u_wd_div (
    .clk(clk), .rst_n(rst_sync_n), .adv(wd_rise), .msb(wd_clk_o)
  );
endmodule

// File: rtl/itvwd_timer_chk.sv
module itvwd_timer_chk #(
  parameter int unsigned STAGES = 14
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              src_en,
  input logic              sub_sel,
  input logic              ctl_wr,
  input logic [3:0]        ctl_wdata,
  input logic              wd_lock,
  input logic              irq_mask,
  input logic [STAGES-1:0] cnt,
  input logic [3:0]        ctl_value,
  input logic              tick_o,
  input logic              irq_o
);
  // R1
  ctl_reset_chk: assert property (@(posedge clk)
    $rose(rst_sync_n) |-> ctl_value == 4'hF);

  // R2
  ctl_load_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ctl_wr |=> ctl_value == $past(ctl_wdata));

  // R2
  ctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !ctl_wr |=> $stable(ctl_value));

  // R3
  restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ctl_wr && ctl_wdata[3] && wd_lock) |=> cnt == '0);

  // R4
  lock_block_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ctl_wr && !wd_lock && src_en && !sub_sel) |=> cnt == STAGES'($past(cnt) + 1'b1));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!src_en && !(ctl_wr && ctl_wdata[3] && wd_lock)) |=> $stable(cnt));

  // R6
  tick_width_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    tick_o |=> !tick_o);

  // R7
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq_o |-> (tick_o && irq_mask));
endmodule

bind itvwd_timer itvwd_timer_chk #(.STAGES(STAGES)) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .src_en(src_en), .sub_sel(sub_sel),
  .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .wd_lock(wd_lock),
  .irq_mask(irq_mask), .cnt(stage_q), .ctl_value(ctl_value),
  .tick_o(tick_o), .irq_o(irq_o)
);

// File: tb/test_itvwd_timer.sv
`timescale 1ns/1ps
module test_itvwd_timer;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       src_en, sub_sel, ctl_wr, wd_lock, irq_mask;
  logic [3:0] ctl_wdata;
  logic [1:0] wd_sel;
  logic [3:0] ctl_value;
  logic       tick_o, irq_o, wd_clk_o;

  int errors = 0;
  int checks = 0;
  string phase = "R1";

  always #4 clk = ~clk;

  itvwd_timer i_itvwd_timer (
    .clk(clk), .rst_n(rst_n), .src_en(src_en), .sub_sel(sub_sel),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .wd_lock(wd_lock),
    .wd_sel(wd_sel), .irq_mask(irq_mask), .ctl_value(ctl_value),
    .tick_o(tick_o), .irq_o(irq_o), .wd_clk_o(wd_clk_o)
  );

  typedef struct {
    logic [3:0] ctl;
    logic       tick;
    logic       irq;
    logic       wdc;
    string      req;
  } exp_t;
  exp_t sb_q[$];

  // reference mappings from R5 and R10
  function automatic int itv_k(input logic [2:0] c);
    int tbl[8] = '{1, 2, 3, 4, 5, 6, 8, 11};
    return tbl[c];
  endfunction
  function automatic int wd_k(input logic [1:0] c);
    return (c == 2'd0) ? 8 : (c == 2'd1) ? 11 : 14;
  endfunction
  function automatic logic bit_of(input int v, input int k);
    return logic'((v >> (k - 1)) & 1);
  endfunction

  // reference model state
  logic m_s1, m_s2;
  logic [3:0] m_ctl;
  int m_cnt, m_pre, m_wdc;
  logic m_iprev, m_wprev, m_it, m_wt, m_tick;
  exp_t e;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_ctl = 4'hF; m_cnt = 0; m_pre = 0; m_wdc = 0;
      m_iprev = 0; m_wprev = 0;
    end else begin
      if (!m_s2) begin
        m_ctl = 4'hF; m_cnt = 0; m_pre = 0; m_wdc = 0; m_iprev = 0; m_wprev = 0;
      end else begin
        m_it = bit_of(m_cnt, itv_k(m_ctl[2:0]));
        m_wt = bit_of(m_cnt, wd_k(wd_sel));
        if (m_wt && !m_wprev) m_wdc = (m_wdc + 1) % 8;
        m_wprev = m_wt;
        m_iprev = m_it;
        if (ctl_wr && ctl_wdata[3] && wd_lock) begin
          m_cnt = 0; m_pre = 0;
        end else if (src_en) begin
          if (sub_sel) begin
            if (m_pre == 15) begin m_pre = 0; m_cnt = (m_cnt + 1) % 16384; end
            else m_pre = m_pre + 1;
          end else m_cnt = (m_cnt + 1) % 16384;
        end
        if (ctl_wr) m_ctl = ctl_wdata;
      end
      m_s2 = m_s1;
      m_s1 = 1'b1;
      m_tick = bit_of(m_cnt, itv_k(m_ctl[2:0])) & ~m_iprev;
      e.ctl = m_ctl; e.tick = m_tick; e.irq = m_tick & irq_mask;
      e.wdc = logic'((m_wdc >> 2) & 1); e.req = phase;
      sb_q.push_back(e);
    end
  end

  // monitor
  exp_t g;
  always @(negedge clk) begin
    if (!rst_n) begin
      checks++;
      if (ctl_value !== 4'hF || tick_o !== 1'b0 || irq_o !== 1'b0 || wd_clk_o !== 1'b0) begin
        errors++;
        $display("FAIL R1 reset: ctl=%h tick=%b irq=%b wdc=%b exp ctl=f tick=0 irq=0 wdc=0",
                 ctl_value, tick_o, irq_o, wd_clk_o);
      end
    end else if (sb_q.size() > 0) begin
      g = sb_q.pop_front();
      checks++;
      if (ctl_value !== g.ctl || tick_o !== g.tick || irq_o !== g.irq || wd_clk_o !== g.wdc) begin
        errors++;
        $display("FAIL %s @%0t: ctl=%h tick=%b irq=%b wdc=%b exp ctl=%h tick=%b irq=%b wdc=%b",
                 g.req, $time, ctl_value, tick_o, irq_o, wd_clk_o, g.ctl, g.tick, g.irq, g.wdc);
      end
    end
  end

  // driver tasks
  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] d, input logic lock);
    @(negedge clk); #1;
    ctl_wr = 1'b1; ctl_wdata = d; wd_lock = lock;
    @(negedge clk); #1;
    ctl_wr = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 0; src_en = 0; sub_sel = 0; ctl_wr = 0; ctl_wdata = 0;
    wd_lock = 1; wd_sel = 0; irq_mask = 1;
    phase = "R1";
    run(5);
    // R11: write arriving during synchronized release is ignored
    #1; phase = "R11";
    rst_n = 1; ctl_wr = 1; ctl_wdata = 4'h2; src_en = 1;
    @(negedge clk); #1; ctl_wr = 0;
    run(6);
    // R5 / R6 / R7 / R2: every interval select code, steady enable
    for (int c = 0; c < 8; c++) begin
      phase = "R5";
      wr({1'b0, 3'(c)}, 1'b1);
      run(3 * (1 << itv_k(3'(c))) + 7);
    end
    phase = "R7";
    irq_mask = 0;
    wr(4'h1, 1'b1);
    run(60);
    irq_mask = 1;
    // R3: restart with lock high mid-count
    phase = "R3";
    wr(4'hA, 1'b1);
    run(37);
    wr(4'hB, 1'b1);
    run(50);
    // R4: lock low blocks restart; bit3=0 never restarts
    phase = "R4";
    wr(4'hB, 1'b0);
    run(21);
    wr(4'h3, 1'b1);
    run(40);
    // R8: ragged enable
    phase = "R8";
    wr(4'h1, 1'b1);
    for (int i = 0; i < 400; i++) begin
      @(negedge clk); #1; src_en = logic'($urandom_range(0, 1));
    end
    src_en = 1;
    // R9: divided sub-clock, including restart of the prestage
    phase = "R9";
    sub_sel = 1;
    wr(4'h8, 1'b1);
    run(300);
    wr(4'h8, 1'b1);
    run(13);
    wr(4'h9, 1'b1);
    run(500);
    sub_sel = 0;
    // R10: watchdog taps
    phase = "R10";
    wd_sel = 2'd0; run(5000);
    wd_sel = 2'd1; run(20000);
    wd_sel = 2'd3; run(62000);
    run(2);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule